// File: doc/BRIEF.md
# Double-Buffered Color Matrix Converter

This block converts a stream of three-channel pixels (RGB or YCbCr) through a per-channel scale-and-bias stage followed by a 3x4 signed matrix. The fourth column of the matrix adds a constant offset to each output channel. The block holds two complete coefficient banks. Software fills whichever bank is idle through a word-wide write port, then requests a new mode. The request waits until the next frame-start pulse, so every frame runs entirely on one consistent set of coefficients. The mode that is currently in force can be read on a status output, which lets software pick the idle bank before writing.

A bypass mode forwards pixels untouched, skipping both the scale/bias stage and the matrix. The data path is a two-stage pipeline that accepts one pixel per cycle. Outputs are rounded and clamped to the unsigned pixel range.

Top module: `color_matrix_dbuf`

## Requirements
- R1: While reset is asserted and after it is released, `stat_mode` is 0 (bypass) and `pix_out_valid` is low. Every coefficient resets to zero. Every scale resets to 1.0 (0x4000) and every bias resets to 0.
- R2: Each pixel accepted with `pix_in_valid` high gives exactly one output with `pix_out_valid` high two clock edges later, and outputs leave in input order.
- R3: In mode 0, `pix_out` equals `pix_in` bit for bit, whatever the scale, bias and coefficient settings.
- R4: In a matrix mode, output channel r is computed as follows. Take the sum over j of C[r][j]*t[j], add C[r][3]*2^13, and add 2^12. Shift the result arithmetically right by 13 bits, then clamp it. C[r][0..2] are signed s2.13 values, and C[r][3] is a signed offset in output LSBs.
- R5: A result below 0 is output as 0, and a result above 65535 is output as 65535.
- R6: Each channel has a prescale register. The scale sits in bits [15:0] as unsigned 2.14, and the bias sits in bits [31:16] as an unsigned value. The prescale registers are at address 16 for channel 0, 17 for channel 1 and 18 for channel 2. The prescaled value is t = floor(x*scale/2^14) - bias. For example, a bias of 0x8000 recentres a chroma channel. Prescale writes take effect for the next accepted pixel.
- R7: Bank 0 coefficients are at addresses 0..5 and bank 1 coefficients are at addresses 8..13. Word k holds C[k/2][2*(k%2)] in bits [15:0] and C[k/2][2*(k%2)+1] in bits [31:16]. Coefficients are numbered row by row, with columns 0..3 in each row.
- R8: A write to address 24 requests a mode. Value 0 requests bypass, 4 requests bank 0 and 5 requests bank 1. Any other value leaves the pending request unchanged.
- R9: A requested mode takes effect only at a clock edge where `frame_start` is high. A pixel accepted on that same edge already uses the new mode. Until then, pixels keep using the old mode.
- R10: A coefficient write to the bank that the active mode selects is ignored. A write to the idle bank takes effect at once.
- R11: `stat_mode` shows the active mode (0, 4 or 5), starting from the cycle after the applying frame-start edge.
- Channel packing: `pix_in` and `pix_out` carry channel 0 (R/Y) in bits [15:0], channel 1 (G/Cb) in bits [31:16] and channel 2 (B/Cr) in bits [47:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse marking the first cycle of a frame |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in | input | 48 | Input pixel, three 16-bit channels |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 48 | Output pixel, three 16-bit channels |
| stat_mode | output | 3 | Active mode: 0 bypass, 4 bank 0, 5 bank 1 |

## Verification
A wrong active-mode register shows up in two places. On the next cycle, `stat_mode` reports the wrong value. Two edges later, the next valid pixel comes out with the wrong transform, for example raw when it should be transformed, or computed with the wrong bank. A missed write-protect shows only on the next pixel processed with the active bank: that pixel carries the corrupted coefficient. The bench therefore pairs every mode change and every blocked or allowed write with both a status sample and a following pixel, whose expected value is predicted from the requirements.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  localparam int NCH    = 3;
  localparam int NCOL   = NCH + 1;
  localparam int NCOEF  = NCH * NCOL;
  localparam int NBANK  = 2;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 5'd24;

  typedef enum logic [2:0] {
    MODE_BYPASS = 3'd0,
    MODE_BANK0  = 3'd4,
    MODE_BANK1  = 3'd5
  } cmx_mode_e;

endpackage

// File: rtl/cmx_ctrl.sv
module cmx_ctrl
  import cmx_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int SCALE_FRAC = 14
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [ADDR_W-1:0]                        cfg_addr,
  input  logic [2*COEF_W-1:0]                      cfg_wdata,
  input  logic                                     frame_start,
  output cmx_mode_e                                act_mode,
  output cmx_mode_e                                pix_mode,
  output logic [NBANK-1:0][NCOEF-1:0][COEF_W-1:0]  coef,
  output logic [NCH-1:0][COEF_W-1:0]               scale,
  output logic [NCH-1:0][COEF_W-1:0]               bias
);

  localparam logic [COEF_W-1:0] SCALE_ONE = COEF_W'(1 << SCALE_FRAC);
  localparam int                WORDS     = NCOEF / 2;

  logic [NBANK-1:0][NCOEF-1:0][COEF_W-1:0] coef_q, coef_d;
  logic [NCH-1:0][COEF_W-1:0]              scale_q, scale_d, bias_q, bias_d;
  cmx_mode_e                               act_q, act_d, pend_q, pend_d;

  logic [2:0] word;
  logic       wbank;
  logic       hit_coef, hit_pre, hit_mode;
  logic       bank_busy, coef_wr, pre_wr, mode_ok, mode_wr;

  assign word      = cfg_addr[2:0];
  assign wbank     = cfg_addr[3];
  assign hit_coef  = cfg_we && !cfg_addr[4] && (int'(word) < WORDS);
  assign hit_pre   = cfg_we && (cfg_addr[4:3] == 2'b10) && (int'(word) < NCH);
  assign hit_mode  = cfg_we && (cfg_addr == ADDR_MODE);
  assign bank_busy = wbank ? (act_q == MODE_BANK1) : (act_q == MODE_BANK0);
  assign coef_wr   = hit_coef && !bank_busy;
  assign pre_wr    = hit_pre;
  assign mode_ok   = (cfg_wdata == 32'(MODE_BYPASS)) || (cfg_wdata == 32'(MODE_BANK0)) ||
                     (cfg_wdata == 32'(MODE_BANK1));
  assign mode_wr   = hit_mode && mode_ok;

  always_comb begin
    coef_d = coef_q;
    if (coef_wr) begin
      coef_d[wbank][2*int'(word)]   = cfg_wdata[COEF_W-1:0];
      coef_d[wbank][2*int'(word)+1] = cfg_wdata[2*COEF_W-1:COEF_W];
    end
  end

  always_comb begin
    scale_d = scale_q;
    bias_d  = bias_q;
    if (pre_wr) begin
      scale_d[int'(word)] = cfg_wdata[COEF_W-1:0];
      bias_d[int'(word)]  = cfg_wdata[2*COEF_W-1:COEF_W];
    end
  end

  always_comb begin
    pend_d = mode_wr ? cmx_mode_e'(cfg_wdata[2:0]) : pend_q;
    act_d  = frame_start ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (coef_wr) begin
      coef_q <= coef_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= {NCH{SCALE_ONE}};
      bias_q  <= '0;
    end else if (pre_wr) begin
      scale_q <= scale_d;
      bias_q  <= bias_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= MODE_BYPASS;
      act_q  <= MODE_BYPASS;
    end else begin
      if (mode_wr)     pend_q <= pend_d;
      if (frame_start) act_q  <= act_d;
    end
  end

  assign act_mode = act_q;
  assign pix_mode = frame_start ? pend_q : act_q;
  assign coef     = coef_q;
  assign scale    = scale_q;
  assign bias     = bias_q;

  // R9: the active mode moves only on a frame-start edge
  assert_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_q));

  // R9: on a frame-start edge the pending request becomes active
  assert_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_q == $past(pend_q)));

  // R10: a write aimed at the bank in use leaves all coefficients as they were
  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_coef && bank_busy) |=> $stable(coef_q));

  // R8: an unsupported mode value never becomes pending
  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mode && !mode_ok) |=> $stable(pend_q));

endmodule

// File: rtl/cmx_prescale.sv
module cmx_prescale #(
  parameter int PIX_W      = 16,
  parameter int COEF_W     = 16,
  parameter int SCALE_FRAC = 14,
  parameter int T_W        = PIX_W + COEF_W - SCALE_FRAC + 1
) (
  input  logic [PIX_W-1:0]     px,
  input  logic [COEF_W-1:0]    scale,
  input  logic [COEF_W-1:0]    bias,
  output logic signed [T_W-1:0] t
);

  localparam int PROD_W = PIX_W + COEF_W;
  localparam int SHR_W  = PROD_W - SCALE_FRAC;

  logic [PROD_W-1:0] prod;
  logic [SHR_W-1:0]  scaled;

  assign prod   = PROD_W'(px) * PROD_W'(scale);
  assign scaled = SHR_W'(prod >> SCALE_FRAC);
  assign t      = $signed({1'b0, scaled}) - $signed({{(T_W-COEF_W){1'b0}}, bias});

endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
#(
  parameter int PIX_W     = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 13,
  parameter int T_W       = 19
) (
  input  logic [NCOL-1:0][COEF_W-1:0] coef_row,
  input  logic [NCH-1:0][T_W-1:0]     t_in,
  output logic [PIX_W-1:0]            y
);

  localparam int ACC_W = COEF_W + T_W + 3;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (COEF_FRAC - 1);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    logic signed [ACC_W-1:0] ce, te, off;
    off = ACC_W'($signed(coef_row[NCOL-1]));
    acc = (off <<< COEF_FRAC) + HALF;
    for (int j = 0; j < NCH; j++) begin
      ce  = ACC_W'($signed(coef_row[j]));
      te  = ACC_W'($signed(t_in[j]));
      acc = acc + ce * te;
    end
  end

  assign shifted = acc >>> COEF_FRAC;

  always_comb begin
    if (shifted[ACC_W-1]) begin
      y = '0;
    end else if (|shifted[ACC_W-2:PIX_W]) begin
      y = '1;
    end else begin
      y = shifted[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/color_matrix_dbuf.sv
module color_matrix_dbuf
  import cmx_pkg::*;
#(
  parameter int PIX_W      = 16,
  parameter int COEF_W     = 16,
  parameter int COEF_FRAC  = 13,
  parameter int SCALE_FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [2*COEF_W-1:0]  cfg_wdata,
  input  logic                 frame_start,
  input  logic                 pix_in_valid,
  input  logic [NCH*PIX_W-1:0] pix_in,
  output logic                 pix_out_valid,
  output logic [NCH*PIX_W-1:0] pix_out,
  output logic [2:0]           stat_mode
);

  localparam int T_W = PIX_W + COEF_W - SCALE_FRAC + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cmx_mode_e                               act_mode, pix_mode;
  logic [NBANK-1:0][NCOEF-1:0][COEF_W-1:0] coef;
  logic [NCH-1:0][COEF_W-1:0]              scale, bias;

  cmx_ctrl #(.COEF_W(COEF_W), .SCALE_FRAC(SCALE_FRAC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .frame_start(frame_start),
    .act_mode   (act_mode),
    .pix_mode   (pix_mode),
    .coef       (coef),
    .scale      (scale),
    .bias       (bias)
  );

  // stage 1: prescale
  logic [NCH-1:0][T_W-1:0] t_d, s1_t_q;
  logic [NCH*PIX_W-1:0]    s1_raw_q;
  logic                    s1_valid_q, s1_bypass_q, s1_bank_q;
  logic                    s1_bypass_d, s1_bank_d;

  for (genvar c = 0; c < NCH; c++) begin : g_pre
    cmx_prescale #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .SCALE_FRAC(SCALE_FRAC), .T_W(T_W)
    ) u_pre (
      .px   (pix_in[c*PIX_W +: PIX_W]),
      .scale(scale[c]),
      .bias (bias[c]),
      .t    (t_d[c])
    );
  end

  assign s1_bypass_d = (pix_mode == MODE_BYPASS);
  assign s1_bank_d   = (pix_mode == MODE_BANK1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) s1_valid_q <= 1'b0;
    else         s1_valid_q <= pix_in_valid;
  end

  always_ff @(posedge clk) begin
    if (pix_in_valid) begin
      s1_t_q      <= t_d;
      s1_raw_q    <= pix_in;
      s1_bypass_q <= s1_bypass_d;
      s1_bank_q   <= s1_bank_d;
    end
  end

  // stage 2: matrix rows
  logic [NCOEF-1:0][COEF_W-1:0] bank_coef;
  logic [NCH-1:0][PIX_W-1:0]    y_d;
  logic [NCH*PIX_W-1:0]         out_d;

  assign bank_coef = coef[s1_bank_q];

  for (genvar r = 0; r < NCH; r++) begin : g_row
    cmx_row #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .T_W(T_W)
    ) u_row (
      .coef_row(bank_coef[r*NCOL +: NCOL]),
      .t_in    (s1_t_q),
      .y       (y_d[r])
    );
  end

  assign out_d = s1_bypass_q ? s1_raw_q : y_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pix_out_valid <= 1'b0;
    else         pix_out_valid <= s1_valid_q;
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) pix_out <= out_d;
  end

  assign stat_mode = act_mode;

  // R2: every accepted pixel reaches the output two edges later
  assert_stage1_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    pix_in_valid |=> s1_valid_q);
  assert_stage2_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    s1_valid_q |=> pix_out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !s1_valid_q |=> !pix_out_valid);

  // R3: a bypassed pixel leaves exactly as it entered stage 1
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (s1_valid_q && s1_bypass_q) |=> (pix_out == $past(s1_raw_q)));

endmodule

// File: tb/color_matrix_dbuf_bench.sv
module color_matrix_dbuf_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frame_start;
  logic        pix_in_valid;
  logic [47:0] pix_in;
  logic        pix_out_valid;
  logic [47:0] pix_out;
  logic [2:0]  stat_mode;

  always #4 clk = ~clk;

  color_matrix_dbuf u_color_matrix_dbuf (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .pix_in_valid(pix_in_valid), .pix_in(pix_in),
    .pix_out_valid(pix_out_valid), .pix_out(pix_out), .stat_mode(stat_mode)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [47:0] exp_q[$];
  string       tag_q[$];

  longint m_coef[2][12];
  longint m_scale[3];
  longint m_bias[3];
  int     m_act;
  int     m_pend;

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint clamp16(longint v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  function automatic logic [47:0] predict(logic [47:0] x);
    longint t[3];
    logic [47:0] y;
    int b;
    if (m_act == 0) return x;
    b = (m_act == 5) ? 1 : 0;
    for (int c = 0; c < 3; c++)
      t[c] = ((longint'(x[c*16 +: 16]) * m_scale[c]) >>> 14) - m_bias[c];
    for (int r = 0; r < 3; r++) begin
      longint acc;
      acc = (m_coef[b][r*4+3] <<< 13) + 4096;
      for (int j = 0; j < 3; j++) acc += m_coef[b][r*4+j] * t[j];
      y[r*16 +: 16] = 16'(clamp16(acc >>> 13));
    end
    return y;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    frame_start = 1'b0;
    pix_in_valid = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    int k;
    k = int'(a[2:0]);
    if (!a[4] && k < 6) begin
      int b;
      b = a[3] ? 1 : 0;
      if (!((b == 0 && m_act == 4) || (b == 1 && m_act == 5))) begin
        m_coef[b][2*k]   = longint'($signed(d[15:0]));
        m_coef[b][2*k+1] = longint'($signed(d[31:16]));
      end
    end else if (a[4:3] == 2'b10 && k < 3) begin
      m_scale[k] = longint'(d[15:0]);
      m_bias[k]  = longint'(d[31:16]);
    end else if (a == 5'd24 && (d == 0 || d == 4 || d == 5)) begin
      m_pend = int'(d);
    end
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    tick();
  endtask

  task automatic pix(logic [47:0] x, bit fs, string tag);
    if (fs) m_act = m_pend;
    exp_q.push_back(predict(x));
    tag_q.push_back(tag);
    pix_in = x;
    pix_in_valid = 1'b1;
    frame_start = fs;
    tick();
  endtask

  task automatic frame_only();
    m_act = m_pend;
    frame_start = 1'b1;
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check_stat(string tag, int exp);
    @(negedge clk);
    check(tag, longint'(stat_mode), longint'(exp));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pix_out_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R2 unexpected output actual=%0h expected=none", pix_out);
      end else begin
        logic [47:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, longint'(pix_out), longint'(e));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 12; i++) m_coef[b][i] = 0;
    for (int c = 0; c < 3; c++) begin
      m_scale[c] = 16384;
      m_bias[c]  = 0;
    end
    m_act = 0;
    m_pend = 0;
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frame_start = 1'b0; pix_in_valid = 1'b0; pix_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 stat in reset", longint'(stat_mode), 0);
    check("R1 valid in reset", longint'(pix_out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(3);
    check_stat("R1 stat after reset", 0);
    check("R1 valid after reset", longint'(pix_out_valid), 0);

    // bypass ignores prescale
    wr(5'd16, {16'h0100, 16'h2000});
    pix(48'hFFFF_0000_1234, 0, "R3 bypass a");
    pix(48'h0001_8000_FFFF, 0, "R3 bypass b");
    pix(48'hA5A5_5A5A_0F0F, 0, "R3 bypass c");
    wr(5'd16, {16'h0000, 16'h4000});

    // pending request held until frame start; zero-reset bank 1
    wr(5'd24, 32'd5);
    check_stat("R9 pending not yet active", 0);
    pix(48'h0300_0200_0100, 0, "R9 old mode before frame");
    pix(48'h0300_0200_0100, 1, "R1 reset coefficients zero on frame pixel");
    check_stat("R11 stat bank1", 5);

    // fill idle bank 0: identity with offsets +16 / 0 / -16
    wr(5'd0, {16'h0000, 16'h2000});
    wr(5'd1, {16'h0010, 16'h0000});
    wr(5'd2, {16'h2000, 16'h0000});
    wr(5'd3, {16'h0000, 16'h0000});
    wr(5'd4, {16'h0000, 16'h0000});
    wr(5'd5, {16'hFFF0, 16'h2000});
    wr(5'd24, 32'd4);
    frame_only();
    check_stat("R11 stat bank0", 4);
    pix(48'h0300_0200_0100, 0, "R4 identity offsets");
    pix(48'h0008_FFFF_FFF8, 0, "R5 offset clamps");
    pix(48'h1234_5678_9ABC, 0, "R7 bank0 packing");

    // prescale: chroma recentre and half scale
    wr(5'd17, {16'h8000, 16'h4000});
    wr(5'd18, {16'h0000, 16'h2000});
    pix(48'h4000_9000_0100, 0, "R6 bias 0x8000 and scale");
    pix(48'h4000_7000_0100, 0, "R6 bias below zero");
    wr(5'd17, {16'h0000, 16'h4000});
    wr(5'd18, {16'h0000, 16'h4000});

    // write to active bank 0 is ignored
    wr(5'd0, {16'h0000, 16'h4000});
    pix(48'h0300_0200_0100, 0, "R10 active bank write ignored");

    // fill idle bank 1 with a mixing matrix
    wr(5'd8,  {16'h0800, 16'h1000});
    wr(5'd9,  {16'h0000, 16'h0800});
    wr(5'd10, {16'h0000, 16'hE000});
    wr(5'd11, {16'h0000, 16'h0000});
    wr(5'd12, {16'h0000, 16'h6000});
    wr(5'd13, {16'h7FFF, 16'h0000});
    wr(5'd24, 32'd5);
    pix(48'h0400_0800_1000, 0, "R9 last pixel of old frame");
    pix(48'h0400_0800_1000, 1, "R9 same-cycle frame pixel");
    check_stat("R11 stat bank1 again", 5);
    pix(48'hFFFF_FFFF_FFFF, 0, "R5 saturate high and low");
    pix(48'h0000_0000_0000, 0, "R4 mix zero input");
    pix(48'h1111_2222_3333, 0, "R4 mix pattern");

    // bank 0 now idle: write accepted
    wr(5'd0, {16'h0000, 16'h4000});
    wr(5'd24, 32'd4);
    frame_only();
    pix(48'h0300_0200_0100, 0, "R10 idle bank write applied");

    // illegal mode values leave request unchanged
    wr(5'd24, 32'd3);
    wr(5'd24, 32'd7);
    frame_only();
    check_stat("R8 illegal mode ignored", 4);
    pix(48'h0123_0456_0789, 0, "R8 still bank0");

    // back to bypass
    wr(5'd24, 32'd0);
    frame_only();
    check_stat("R11 stat bypass", 0);
    pix(48'hDEAD_BEEF_CAFE, 0, "R3 bypass after matrix");

    idle(6);
    check("R2 all outputs drained", longint'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule